// File: doc/BRIEF.md
# Byte-Coded Command Sequencer

The sequencer runs a short program of byte-coded instructions held in an on-block program RAM. A host fills the RAM through a byte write port and pulses `start`. The sequencer then fetches one byte per cycle and executes the instructions in order. Instructions are one, three or five bytes long. They can idle for a packed delay, load a 32-bit address or data register (the whole register or only its low half), set a bank of 32 flag outputs, stall until one of the event inputs reaches a chosen level, or stop.

Every load of the data register produces a one-cycle write strobe that presents the held address together with the new data. A flag is either released (its enable is low) or driven to 0 or 1. An undecodable opcode stops the run with an error. Running off the end of the program RAM also stops the run with an error. A `done` pulse marks a clean stop.

The controller is a single state machine with these states:

- `ST_IDLE`: not running.
- `ST_FETCH`: reads and decodes an opcode byte.
- `ST_OPND`: gathers immediate bytes.
- `ST_DELAY`: counts out a wait.
- `ST_EVWAIT`: stalls on an event.
- `ST_FAULT`: stopped with an error.

Transitions:

- Any state goes to `ST_FETCH` on `start`.
- `ST_FETCH` goes to `ST_FETCH` on a no-op, a flag op or a zero-length wait.
- `ST_FETCH` goes to `ST_DELAY` on a wait with a non-zero length.
- `ST_FETCH` goes to `ST_OPND` on a multi-byte opcode.
- `ST_FETCH` goes to `ST_IDLE` on exit.
- `ST_FETCH` goes to `ST_FAULT` on an illegal opcode or a program-counter overflow.
- `ST_OPND` goes to `ST_FETCH` after the last immediate byte of a register load.
- `ST_OPND` goes to `ST_EVWAIT` after the last immediate byte of an event wait.
- `ST_OPND` goes to `ST_FAULT` on a program-counter overflow.
- `ST_DELAY` goes to `ST_FETCH` when the count ends.
- `ST_EVWAIT` goes to `ST_FETCH` when the event matches.

Top module: `cmdseq_top`

## Requirements
- R1: A `start` pulse sets the program counter to 0, clears `error`, releases every flag (all of `flag_oe` and `flag_val` read 0 in the next cycle) and raises `busy` in the next cycle.
- R2: Opcode 0x00 is a no-op, and every one-byte opcode other than a non-zero wait takes exactly one cycle.
- R3: Opcodes 0x01–0x3F are waits. The delay is D = op[1:0] << op[5:2], and the wait takes 1 + D cycles.
- R4: Opcode 0xE0 loads the 32-bit address from the next four bytes, least significant byte first. Opcode 0x40 replaces only address bits [15:0] from the next two bytes, least significant byte first. Neither produces a strobe.
- R5: Opcodes 0xE2 and 0x42 load the data register in the same way as R4. In the cycle after the last immediate byte, `wr_stb` is high for exactly one cycle with `wr_addr` equal to the held address and `wr_data` equal to the new data.
- R6: For flag index N = op[4:0]:
  - Opcodes 0x80+N release flag N (enable 0, value 0).
  - Opcodes 0xA0+N drive flag N to 1 (enable 1).
  - Opcodes 0xC0+N drive flag N to 0 (enable 1).
- R7: Opcode 0x5F is a three-byte event wait. Bits [4:0] of byte 1 select an event and bit 0 of byte 2 gives the awaited level. The sequencer stalls until `ev_in[sel]` equals that level and resumes fetching one cycle after it matches. Event selects of NUM_EV or more read as 0.
- R8: Opcode 0x7F ends the run. `busy` falls and `done` is high for exactly one cycle.
- R9: Every opcode not listed in R2–R8 is illegal. It stops the run after its fetch cycle, raises `error` with `busy` low, and `error` holds until the next `start`.
- R10: A fetch of an opcode or an immediate byte at program address PROG_DEPTH or beyond stops the run with `error` high.
- R11: After reset the outputs `busy`, `done`, `error` and `wr_stb` are 0, every flag is released, and `wr_addr` and `wr_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin execution at program address 0 |
| ev_in | input | NUM_EV | Event levels |
| ld_en | input | 1 | Program RAM write enable |
| ld_addr | input | $clog2(PROG_DEPTH) | Program RAM write address |
| ld_byte | input | 8 | Program RAM write byte |
| wr_stb | output | 1 | One-cycle register-write strobe |
| wr_addr | output | 32 | Address register |
| wr_data | output | 32 | Data register |
| flag_val | output | 32 | Flag values |
| flag_oe | output | 32 | Flag enables |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle pulse on exit |
| error | output | 1 | Illegal opcode or program overflow |

## Verification
Each opcode byte and each immediate byte costs one cycle from the edge that samples `start`. As a result, busy lasts exactly the sum of the instruction lengths plus any wait or stall cycles, and the bench compares the measured busy length against that arithmetic sum for every wait opcode up to shift 7 and for selected larger shifts. A strobe is due in the cycle that follows the last immediate byte of a data load, so the bench records the cycle index of each strobe and compares it against the byte offset. Event waits are held off for a dozen cycles and must finish exactly two cycles after the matching level is applied. Illegal opcodes are swept over all 256 byte values and must fault after one cycle.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_OPND,
        ST_DELAY,
        ST_EVWAIT,
        ST_FAULT
    } seq_state_t;

    typedef enum logic [1:0] {
        FL_KEEP,
        FL_RELEASE,
        FL_HIGH,
        FL_LOW
    } flag_op_t;

    typedef enum logic [2:0] {
        K_ADDR_LO,
        K_DATA_LO,
        K_ADDR_FULL,
        K_DATA_FULL,
        K_EVENT
    } opnd_kind_t;

    localparam int BASE_W  = 2;
    localparam int SHIFT_W = 4;
    localparam int DLY_W   = BASE_W + (1 << SHIFT_W) - 1;
    localparam int REG_W   = 32;
    localparam int FLAG_N  = 32;

endpackage

// File: rtl/cmdseq_progmem.sv
module cmdseq_progmem #(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_byte,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_byte
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_byte;
        end
    end

    assign rd_byte = mem[rd_addr];

endmodule

// File: rtl/cmdseq_timer.sv
module cmdseq_timer #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == W'(1));

endmodule

// File: rtl/cmdseq_flags.sv
module cmdseq_flags
    import cmdseq_pkg::*;
#(
    parameter int NF = 32,
    parameter int IW = $clog2(NF)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          op_en,
    input  flag_op_t      op,
    input  logic [IW-1:0] idx,
    output logic [NF-1:0] val,
    output logic [NF-1:0] oe
);

    for (genvar g = 0; g < NF; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val[g] <= 1'b0;
                oe[g]  <= 1'b0;
            end else if (clr) begin
                val[g] <= 1'b0;
                oe[g]  <= 1'b0;
            end else if (op_en && idx == IW'(g)) begin
                unique case (op)
                    FL_RELEASE: begin
                        val[g] <= 1'b0;
                        oe[g]  <= 1'b0;
                    end
                    FL_HIGH: begin
                        val[g] <= 1'b1;
                        oe[g]  <= 1'b1;
                    end
                    FL_LOW: begin
                        val[g] <= 1'b0;
                        oe[g]  <= 1'b1;
                    end
                    default: begin
                        val[g] <= val[g];
                        oe[g]  <= oe[g];
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/cmdseq_top.sv
module cmdseq_top
    import cmdseq_pkg::*;
#(
    parameter int PROG_DEPTH = 64,
    parameter int NUM_EV     = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [NUM_EV-1:0]             ev_in,
    input  logic                          ld_en,
    input  logic [$clog2(PROG_DEPTH)-1:0] ld_addr,
    input  logic [7:0]                    ld_byte,
    output logic                          wr_stb,
    output logic [REG_W-1:0]              wr_addr,
    output logic [REG_W-1:0]              wr_data,
    output logic [FLAG_N-1:0]             flag_val,
    output logic [FLAG_N-1:0]             flag_oe,
    output logic                          busy,
    output logic                          done,
    output logic                          error
);

    localparam int PA_W  = $clog2(PROG_DEPTH);
    localparam int FI_W  = $clog2(FLAG_N);
    localparam int EV_SW = 5;

    seq_state_t st, st_n;

    logic [PA_W:0]      pc;
    logic               ovf;
    logic [7:0]         cur;

    // decode of the byte under the program counter
    logic               d_wait, d_ops, d_exit, d_flag, d_bad;
    opnd_kind_t         d_kind;
    logic [1:0]         d_last;
    logic [DLY_W-1:0]   dly;
    flag_op_t           d_fop;

    // operand gathering
    opnd_kind_t         okind;
    logic [1:0]         oidx, olast;
    logic               o_last;
    logic [REG_W-1:0]   imm, imm_full;

    // event wait
    logic [EV_SW-1:0]   ev_sel;
    logic               ev_lvl;
    logic [31:0]        ev_pad;
    logic               ev_hit;

    logic               tmr_last;
    logic               fetch_go;

    assign ovf = pc[PA_W];

    cmdseq_progmem #(.DEPTH(PROG_DEPTH), .AW(PA_W)) u_mem (
        .clk     (clk),
        .wr_en   (ld_en),
        .wr_addr (ld_addr),
        .wr_byte (ld_byte),
        .rd_addr (pc[PA_W-1:0]),
        .rd_byte (cur)
    );

    always_comb begin
        d_wait = 1'b0;
        d_ops  = 1'b0;
        d_exit = 1'b0;
        d_flag = 1'b0;
        d_bad  = 1'b0;
        d_kind = K_ADDR_LO;
        d_last = 2'd1;
        case (cur) inside
            8'h00:          ;
            [8'h01:8'h3F]:  d_wait = 1'b1;
            8'h40:          d_ops  = 1'b1;
            8'h42: begin
                d_ops  = 1'b1;
                d_kind = K_DATA_LO;
            end
            8'h5F: begin
                d_ops  = 1'b1;
                d_kind = K_EVENT;
            end
            8'hE0: begin
                d_ops  = 1'b1;
                d_kind = K_ADDR_FULL;
                d_last = 2'd3;
            end
            8'hE2: begin
                d_ops  = 1'b1;
                d_kind = K_DATA_FULL;
                d_last = 2'd3;
            end
            8'h7F:          d_exit = 1'b1;
            [8'h80:8'hDF]:  d_flag = 1'b1;
            default:        d_bad  = 1'b1;
        endcase
    end

    assign dly = DLY_W'(cur[BASE_W-1:0]) << cur[BASE_W+SHIFT_W-1:BASE_W];

    always_comb begin
        unique case (cur[6:5])
            2'b00:   d_fop = FL_RELEASE;
            2'b01:   d_fop = FL_HIGH;
            2'b10:   d_fop = FL_LOW;
            default: d_fop = FL_KEEP;
        endcase
    end

    assign fetch_go = (st == ST_FETCH) && !ovf && !start;
    assign o_last   = (oidx == olast);
    assign imm_full = imm | (REG_W'(cur) << {oidx, 3'b000});

    always_comb begin
        ev_pad = '0;
        ev_pad[NUM_EV-1:0] = ev_in;
    end
    assign ev_hit = (ev_pad[ev_sel] == ev_lvl);

    cmdseq_timer #(.W(DLY_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fetch_go && d_wait),
        .load_val (dly),
        .last     (tmr_last)
    );

    cmdseq_flags #(.NF(FLAG_N), .IW(FI_W)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .op_en (fetch_go && d_flag),
        .op    (d_fop),
        .idx   (cur[FI_W-1:0]),
        .val   (flag_val),
        .oe    (flag_oe)
    );

    // next-state logic
    always_comb begin
        st_n = st;
        unique case (st)
            ST_IDLE, ST_FAULT: st_n = st;
            ST_FETCH: begin
                if (ovf || d_bad)            st_n = ST_FAULT;
                else if (d_exit)             st_n = ST_IDLE;
                else if (d_ops)              st_n = ST_OPND;
                else if (d_wait && dly != 0) st_n = ST_DELAY;
                else                         st_n = ST_FETCH;
            end
            ST_OPND: begin
                if (ovf)         st_n = ST_FAULT;
                else if (o_last) st_n = (okind == K_EVENT) ? ST_EVWAIT : ST_FETCH;
            end
            ST_DELAY:  if (tmr_last) st_n = ST_FETCH;
            ST_EVWAIT: if (ev_hit)   st_n = ST_FETCH;
            default:   st_n = ST_IDLE;
        endcase
        if (start) st_n = ST_FETCH;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_n;
    end

    // output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc      <= '0;
            okind   <= K_ADDR_LO;
            oidx    <= '0;
            olast   <= '0;
            imm     <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            wr_stb  <= 1'b0;
            done    <= 1'b0;
            error   <= 1'b0;
            ev_sel  <= '0;
            ev_lvl  <= 1'b0;
        end else begin
            wr_stb <= 1'b0;
            done   <= (st == ST_FETCH) && (st_n == ST_IDLE);
            if (start) begin
                pc    <= '0;
                error <= 1'b0;
            end else begin
                if (st_n == ST_FAULT && st != ST_FAULT) error <= 1'b1;
                if (st == ST_FETCH && !ovf) begin
                    pc <= pc + 1'b1;
                    if (d_ops) begin
                        okind <= d_kind;
                        oidx  <= '0;
                        olast <= d_last;
                        imm   <= '0;
                    end
                end
                if (st == ST_OPND && !ovf) begin
                    pc   <= pc + 1'b1;
                    imm  <= imm_full;
                    oidx <= oidx + 1'b1;
                    if (o_last) begin
                        unique case (okind)
                            K_ADDR_LO:   wr_addr[15:0] <= imm_full[15:0];
                            K_ADDR_FULL: wr_addr <= imm_full;
                            K_DATA_LO: begin
                                wr_data[15:0] <= imm_full[15:0];
                                wr_stb        <= 1'b1;
                            end
                            K_DATA_FULL: begin
                                wr_data <= imm_full;
                                wr_stb  <= 1'b1;
                            end
                            K_EVENT: begin
                                ev_sel <= imm_full[EV_SW-1:0];
                                ev_lvl <= imm_full[8];
                            end
                            default: ;
                        endcase
                    end
                end
            end
        end
    end

    assign busy = (st == ST_FETCH) || (st == ST_OPND) ||
                  (st == ST_DELAY) || (st == ST_EVWAIT);

endmodule

// File: rtl/cmdseq_chk.sv
module cmdseq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        error,
    input logic        wr_stb,
    input logic [31:0] wr_addr,
    input logic [31:0] flag_oe
);

    // R1
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (busy && !error));

    // R1
    start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (flag_oe == '0));

    // R5
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R4
    addr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(wr_addr));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R9
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !busy);

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);

endmodule

bind cmdseq_top cmdseq_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .error   (error),
    .wr_stb  (wr_stb),
    .wr_addr (wr_addr),
    .flag_oe (flag_oe)
);

// File: tb/tb_cmdseq_top.sv
`timescale 1ns/1ps
module tb_cmdseq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  ev_in = '0;
    logic        ld_en = 1'b0;
    logic [5:0]  ld_addr = '0;
    logic [7:0]  ld_byte = '0;
    logic        wr_stb;
    logic [31:0] wr_addr, wr_data, flag_val, flag_oe;
    logic        busy, done, error;

    always #2.5 clk = ~clk;

    cmdseq_top dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ev_in(ev_in),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_byte(ld_byte),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
        .flag_val(flag_val), .flag_oe(flag_oe),
        .busy(busy), .done(done), .error(error)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    logic [7:0]  prog [64];
    int          busy_cnt, n_stb;
    logic [31:0] s_addr [4];
    logic [31:0] s_data [4];
    int          s_idx  [4];

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc >= 190000);
        bad++;
        total++;
        $display("FAIL watchdog (all requirements) actual=%0d expected<190000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic load(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_addr = 6'(i);
            ld_byte = prog[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic run(input int lim);
        kick();
        busy_cnt = 0;
        n_stb    = 0;
        while (busy && busy_cnt < lim) begin
            busy_cnt++;
            @(negedge clk);
            if (wr_stb && n_stb < 4) begin
                s_addr[n_stb] = wr_addr;
                s_data[n_stb] = wr_data;
                s_idx[n_stb]  = busy_cnt;
                n_stb++;
            end
        end
    endtask

    function automatic bit legal(input int op);
        return (op <= 8'h3F) || op == 8'h40 || op == 8'h42 || op == 8'h5F ||
               op == 8'h7F || op == 8'hE0 || op == 8'hE2 ||
               (op >= 8'h80 && op <= 8'hDF);
    endfunction

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        check(busy == 0 && done == 0 && error == 0 && wr_stb == 0, "R11 status", {busy, done, error, wr_stb}, 0);
        check(flag_oe == 0 && flag_val == 0, "R11 flags", flag_oe, 0);
        check(wr_addr == 0 && wr_data == 0, "R11 regs", wr_addr, 0);
        rst_n = 1'b1;

        // R2 no-ops and exit
        for (int i = 0; i < 5; i++) prog[i] = 8'h00;
        prog[5] = 8'h7F;
        load(6);
        run(100);
        check(busy_cnt == 6, "R2 nop cycles", busy_cnt, 6);
        check(done == 1 && error == 0, "R8 done at exit", done, 1);
        @(negedge clk);
        check(done == 0, "R8 done one cycle", done, 0);

        // R3 wait sweep
        for (int op = 1; op < 64; op++) begin
            if (op < 32 || op == 8'h3C || op == 8'h35) begin
                int d;
                d = (op & 3) << (op >> 2);
                prog[0] = 8'(op);
                prog[1] = 8'h7F;
                load(2);
                run(20000);
                check(busy_cnt == d + 2, "R3 wait length", busy_cnt, d + 2);
            end
        end

        // R4 / R5 register loads
        for (int k = 0; k < 4; k++) begin
            logic [31:0] a, d;
            logic [15:0] alo, dlo;
            a   = 32'h1357_9BDF * (k + 1) + k;
            d   = 32'hDEAD_BEEF ^ (k * 32'h0101_0101);
            alo = 16'hABCD - 16'(k);
            dlo = 16'h2211 + 16'(3 * k);
            prog[0] = 8'hE0;
            for (int b = 0; b < 4; b++) prog[1 + b] = a[8*b +: 8];
            prog[5] = 8'hE2;
            for (int b = 0; b < 4; b++) prog[6 + b] = d[8*b +: 8];
            prog[10] = 8'h40; prog[11] = alo[7:0]; prog[12] = alo[15:8];
            prog[13] = 8'h42; prog[14] = dlo[7:0]; prog[15] = dlo[15:8];
            prog[16] = 8'h7F;
            load(17);
            run(100);
            check(busy_cnt == 17, "R4 load cycles", busy_cnt, 17);
            check(n_stb == 2, "R4 R5 strobe count", n_stb, 2);
            check(s_idx[0] == 10 && s_idx[1] == 16, "R5 strobe timing", {s_idx[0], s_idx[1]}, {32'd10, 32'd16});
            check(s_addr[0] == a && s_data[0] == d, "R5 full load", {s_addr[0], s_data[0]}, {a, d});
            check(s_addr[1] == {a[31:16], alo} && s_data[1] == {d[31:16], dlo}, "R4 R5 low half",
                  {s_addr[1], s_data[1]}, {a[31:16], alo, d[31:16], dlo});
        end

        // R6 flag sweep
        begin
            int p;
            logic [31:0] eoe, eval;
            p = 0;
            for (int i = 0; i < 32; i++) begin
                case (i % 3)
                    0: begin prog[p] = 8'hA0 | 8'(i); p++; end
                    1: begin prog[p] = 8'hC0 | 8'(i); p++; end
                    default: begin
                        prog[p] = 8'hA0 | 8'(i); p++;
                        prog[p] = 8'h80 | 8'(i); p++;
                    end
                endcase
                eoe[i]  = (i % 3) != 2;
                eval[i] = (i % 3) == 0;
            end
            prog[p] = 8'h7F; p++;
            load(p);
            run(200);
            check(busy_cnt == p, "R6 flag cycles", busy_cnt, p);
            check(flag_oe == eoe, "R6 flag enables", flag_oe, eoe);
            check(flag_val == eval, "R6 flag values", flag_val, eval);
            prog[0] = 8'h7F;
            load(1);
            run(10);
            check(flag_oe == 0 && flag_val == 0, "R1 start releases", flag_oe, 0);
        end

        // R7 event waits
        for (int sel = 0; sel < 5; sel++) begin
            for (int lvl = 0; lvl < 2; lvl++) begin
                prog[0] = 8'h5F; prog[1] = 8'(sel); prog[2] = 8'(lvl); prog[3] = 8'h7F;
                load(4);
                ev_in = {5{lvl[0]}};
                ev_in[sel] = ~lvl[0];
                kick();
                repeat (12) @(negedge clk);
                check(busy == 1 && done == 0, "R7 stall", busy, 1);
                ev_in[sel] = lvl[0];
                @(negedge clk);
                check(busy == 1, "R7 resume", busy, 1);
                @(negedge clk);
                check(busy == 0 && done == 1, "R7 finish", {busy, done}, 1);
            end
        end
        prog[0] = 8'h5F; prog[1] = 8'h07; prog[2] = 8'h00; prog[3] = 8'h7F;
        load(4);
        ev_in = '1;
        run(50);
        check(busy_cnt == 5 && done == 1, "R7 undefined event reads 0", busy_cnt, 5);

        // R9 illegal opcode sweep
        for (int op = 0; op < 256; op++) begin
            if (!legal(op)) begin
                prog[0] = 8'(op);
                load(1);
                run(10);
                check(error == 1 && busy_cnt == 1 && done == 0, "R9 illegal", {error, 8'(busy_cnt)}, {1'b1, 8'd1});
            end
        end
        repeat (3) @(negedge clk);
        check(error == 1 && busy == 0, "R9 error held", error, 1);
        prog[0] = 8'h7F;
        load(1);
        run(10);
        check(error == 0 && done == 1, "R9 error cleared by start", error, 0);

        // R10 program-counter overflow
        for (int i = 0; i < 64; i++) prog[i] = 8'h00;
        load(64);
        run(200);
        check(error == 1 && busy_cnt == 65, "R10 opcode overflow", busy_cnt, 65);
        prog[62] = 8'hE0;
        load(64);
        run(200);
        check(error == 1 && busy_cnt == 65, "R10 operand overflow", busy_cnt, 65);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule